// File: doc/BRIEF.md
# Block-Aligned Instruction Boundary Checker

This block looks at one aligned block of eight 32-bit code words and works out where the instructions in it begin. Instruction lengths are always resolved by walking forward from word 0, which by convention opens a fresh instruction. No state comes from earlier blocks, so any number of copies can decode separate blocks side by side. Each instruction takes one, two or three words. Its length is held in the top two bits of its first word.

Alongside the block, the caller gives the word offset at which execution enters, such as a jump target. The checker returns a per-word mask of instruction starts and the number of starts. It raises an entry fault when the offset lands inside an instruction. It raises a separate straddle fault when an instruction would run past the last word of the block. The result passes through an optional output register stage, which gives one cycle of latency under a valid-in / valid-out pair.

Top module: `block_boundary_checker`

## Requirements
- R1: Whenever a result is valid, bit 0 of the start mask is set, because word 0 always opens an instruction.
- R2: The length comes from bits [31:30] of an instruction's first word: 2'b00 or 2'b01 means one word, 2'b10 means two, 2'b11 means three. The next start is the current start plus that length. Word i of the block is `blockData[32*i +: 32]`.
- R3: Words covered by an instruction after its first word are never marked as starts, and their top bits have no effect on the result.
- R4: If a start at word k has k plus its length greater than 8, `straddleFault` is 1. That start is still marked, and no later word is marked. Otherwise `straddleFault` is 0.
- R5: `instCount` equals the number of set bits in the start mask, from 1 to 8.
- R6: `entryFault` is 1 exactly when the word at `entryOffset` is not marked as a start. An offset of 0 never sets it.
- R7: With the default registered output, `outValid` is 1 in the cycle after a cycle with `inValid` high and 0 otherwise, and the results belong to that input.
- R8: While `inValid` is low, the result outputs keep their last values.
- R9: After reset, `outValid`, the start mask, the count and both faults are 0.
- R10: Each result depends only on its own block. Blocks presented on consecutive cycles give independent results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Block and entry offset are valid this cycle |
| blockData | input | 256 | Eight code words; word i at bits [32*i+31:32*i] |
| entryOffset | input | 3 | Word index at which execution enters the block |
| outValid | output | 1 | Results are valid |
| startMask | output | 8 | Bit i set when word i starts an instruction |
| instCount | output | 4 | Number of instruction starts |
| entryFault | output | 1 | Entry offset falls inside an instruction |
| straddleFault | output | 1 | An instruction runs past word 7 |

## Verification
Every result (mask, count, both faults) comes out of a single register stage. It is therefore due exactly one rising edge after the cycle in which `inValid` was high, and `outValid` rises on that same edge. The bench drives each block on a falling edge, holds it across one rising edge, and samples all outputs on the next falling edge. It then deasserts `inValid` and checks that the results stay put and `outValid` drops after a further edge. The back-to-back case samples each block's result on the falling edge that follows that block's own capture edge.

// File: rtl/bbc_pkg.sv
package bbc_pkg;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic loadOut;
  } dpStrobes_t;

  // Instruction length in words from the top two bits of its first word.
  function automatic logic [1:0] lenOfCode(input logic [1:0] code);
    case (code)
      2'b11:   return 2'd3;
      2'b10:   return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/bbc_ctrl.sv
module bbc_ctrl
  import bbc_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output dpStrobes_t strobes,
  output logic       outValid
);

  always_comb begin
    strobes         = '0;
    strobes.loadOut = inValid;
  end

  generate
    if (REG_OUT) begin : g_reg
      logic validQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) validQ <= 1'b0;
        else       validQ <= inValid;
      end
      assign outValid = validQ;
    end else begin : g_comb
      assign outValid = inValid;
    end
  endgenerate

endmodule

// File: rtl/bbc_walk_dp.sv
module bbc_walk_dp
  import bbc_pkg::*;
#(
  parameter int WORDS   = 8,
  parameter int WORD_W  = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int OFS_W  = $clog2(WORDS),
  localparam int CNT_W  = $clog2(WORDS + 1),
  localparam int POS_W  = $clog2(WORDS + 3)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobes_t              strobes,
  input  logic [WORDS*WORD_W-1:0] blockData,
  input  logic [OFS_W-1:0]        entryOffset,
  output logic [WORDS-1:0]        startMask,
  output logic [CNT_W-1:0]        instCount,
  output logic                    entryFault,
  output logic                    straddleFault
);

  logic [1:0]       lenW [WORDS];
  logic [WORDS-1:0] walkMask;
  logic             walkStraddle;
  logic [CNT_W-1:0] walkCount;
  logic             walkEntry;

  // Per-word length decode, computed for every word in parallel.
  generate
    for (genvar g = 0; g < WORDS; g++) begin : g_len
      assign lenW[g] = lenOfCode(blockData[g*WORD_W + WORD_W - 1 -: 2]);
    end
  endgenerate

  // Forward walk from word 0: each start points at the next one.
  always_comb begin
    logic [POS_W-1:0] nxt;
    walkMask     = '0;
    walkStraddle = 1'b0;
    walkMask[0]  = 1'b1;
    nxt          = '0;
    for (int j = 0; j < WORDS; j++) begin
      if (walkMask[j]) begin
        nxt = POS_W'(j) + POS_W'(lenW[j]);
        if (nxt > POS_W'(WORDS))      walkStraddle = 1'b1;
        else if (nxt < POS_W'(WORDS)) walkMask[nxt[OFS_W-1:0]] = 1'b1;
      end
    end
  end

  always_comb begin
    walkCount = '0;
    for (int j = 0; j < WORDS; j++) walkCount = walkCount + CNT_W'(walkMask[j]);
  end

  assign walkEntry = ~walkMask[entryOffset];

  generate
    if (REG_OUT) begin : g_outreg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          startMask     <= '0;
          instCount     <= '0;
          entryFault    <= 1'b0;
          straddleFault <= 1'b0;
        end else if (strobes.loadOut) begin
          startMask     <= walkMask;
          instCount     <= walkCount;
          entryFault    <= walkEntry;
          straddleFault <= walkStraddle;
        end
      end
    end else begin : g_outcomb
      assign startMask     = walkMask;
      assign instCount     = walkCount;
      assign entryFault    = walkEntry;
      assign straddleFault = walkStraddle;
    end
  endgenerate

endmodule

// File: rtl/block_boundary_checker.sv
module block_boundary_checker
  import bbc_pkg::*;
#(
  parameter int WORDS   = 8,
  parameter int WORD_W  = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int OFS_W  = $clog2(WORDS),
  localparam int CNT_W  = $clog2(WORDS + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [WORDS*WORD_W-1:0] blockData,
  input  logic [OFS_W-1:0]        entryOffset,
  output logic                    outValid,
  output logic [WORDS-1:0]        startMask,
  output logic [CNT_W-1:0]        instCount,
  output logic                    entryFault,
  output logic                    straddleFault
);

  dpStrobes_t strobes;

  bbc_ctrl #(.REG_OUT(REG_OUT)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  bbc_walk_dp #(.WORDS(WORDS), .WORD_W(WORD_W), .REG_OUT(REG_OUT)) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .blockData     (blockData),
    .entryOffset   (entryOffset),
    .startMask     (startMask),
    .instCount     (instCount),
    .entryFault    (entryFault),
    .straddleFault (straddleFault)
  );

endmodule

// File: rtl/bbc_checker.sv
module bbc_checker #(
  parameter int WORDS   = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int OFS_W  = $clog2(WORDS),
  localparam int CNT_W  = $clog2(WORDS + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [OFS_W-1:0] entryOffset,
  input logic             outValid,
  input logic [WORDS-1:0] startMask,
  input logic [CNT_W-1:0] instCount,
  input logic             entryFault,
  input logic             straddleFault
);

  p_word0_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> startMask[0]);

  p_count_match_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (32'(instCount) == $countones(startMask)));

  p_count_nonzero_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (instCount != '0));

  generate
    if (REG_OUT) begin : g_seq
      p_entry_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && entryOffset == '0) |=> !entryFault);

      p_valid_follow_r7: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> outValid);

      p_valid_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> !outValid);

      p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> ($stable(startMask) && $stable(instCount)
                      && $stable(entryFault) && $stable(straddleFault)));
    end
  endgenerate

endmodule

bind block_boundary_checker bbc_checker #(.WORDS(WORDS), .REG_OUT(REG_OUT)) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .inValid       (inValid),
  .entryOffset   (entryOffset),
  .outValid      (outValid),
  .startMask     (startMask),
  .instCount     (instCount),
  .entryFault    (entryFault),
  .straddleFault (straddleFault)
);

// File: tb/block_boundary_checker_tb.sv
module block_boundary_checker_tb_top;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [255:0] blockData = '0;
  logic [2:0]   entryOffset = '0;
  logic         outValid;
  logic [7:0]   startMask;
  logic [3:0]   instCount;
  logic         entryFault;
  logic         straddleFault;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  block_boundary_checker dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .blockData(blockData),
    .entryOffset(entryOffset), .outValid(outValid), .startMask(startMask),
    .instCount(instCount), .entryFault(entryFault), .straddleFault(straddleFault)
  );

  function automatic logic [31:0] w(input logic [1:0] code, input logic [29:0] pay);
    return {code, pay};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkOut(input string tag, input logic [7:0] m, input logic [3:0] c,
                          input logic ef, input logic sf);
    chk({tag, " R7 outValid"}, 32'(outValid), 32'd1);
    chk({tag, " mask"}, 32'(startMask), 32'(m));
    chk({tag, " R5 count"}, 32'(instCount), 32'(c));
    chk({tag, " R6 entryFault"}, 32'(entryFault), 32'(ef));
    chk({tag, " R4 straddleFault"}, 32'(straddleFault), 32'(sf));
  endtask

  // Drive one block for one cycle and check the registered result.
  task automatic sendBlock(input string tag, input logic [255:0] blk, input logic [2:0] ent,
                           input logic [7:0] m, input logic [3:0] c, input logic ef, input logic sf);
    @(negedge clk);
    blockData = blk; entryOffset = ent; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    checkOut(tag, m, c, ef, sf);
  endtask

  logic [255:0] blkOnes, blkTwos, blkThree, blkStrad, blkSkip, blkTail;

  task automatic testReset();
    chk("R9 outValid", 32'(outValid), 0);
    chk("R9 mask", 32'(startMask), 0);
    chk("R9 count", 32'(instCount), 0);
    chk("R9 faults", 32'({entryFault, straddleFault}), 0);
  endtask

  task automatic testSingles();   // R1 R2: codes 00 and 01 both one word
    sendBlock("R1 R2 singles", blkOnes, 3'd7, 8'hFF, 4'd8, 1'b0, 1'b0);
  endtask

  task automatic testPairs();     // R2 R3 R6: two-word instructions, entry inside one
    sendBlock("R2 R3 pairs", blkTwos, 3'd3, 8'h55, 4'd4, 1'b1, 1'b0);
  endtask

  task automatic testMixed();     // R2 R4: 3+3+2 ends exactly at word 7
    sendBlock("R2 R4 mixed", blkThree, 3'd6, 8'h49, 4'd3, 1'b0, 1'b0);
  endtask

  task automatic testStraddle();  // R4 R6: start at word 7 of length 3
    sendBlock("R4 R6 straddle entry0", blkStrad, 3'd0, 8'h93, 4'd4, 1'b0, 1'b1);
    sendBlock("R4 R6 straddle entry5", blkStrad, 3'd5, 8'h93, 4'd4, 1'b1, 1'b1);
  endtask

  task automatic testSkipped();   // R3: covered words carry codes that must be ignored
    sendBlock("R3 skipped", blkSkip, 3'd1, 8'hF9, 4'd6, 1'b1, 1'b0);
  endtask

  task automatic testTail();      // R4 R6: straddler at word 6, entry at its inner word
    sendBlock("R4 tail", blkTail, 3'd7, 8'h7F, 4'd7, 1'b1, 1'b1);
  endtask

  task automatic testHold();      // R8 R7: idle cycles with changing inputs
    blockData = blkOnes; entryOffset = 3'd1;
    @(negedge clk);
    chk("R7 outValid idle", 32'(outValid), 0);
    chk("R8 mask held", 32'(startMask), 32'h7F);
    chk("R8 count held", 32'(instCount), 7);
    chk("R8 faults held", 32'({entryFault, straddleFault}), 32'h3);
    repeat (3) @(negedge clk);
    chk("R8 mask still held", 32'(startMask), 32'h7F);
  endtask

  task automatic testBackToBack(); // R10 R7: consecutive blocks
    @(negedge clk);
    blockData = blkStrad; entryOffset = 3'd1; inValid = 1'b1;
    @(negedge clk);
    checkOut("R10 first", 8'h93, 4'd4, 1'b0, 1'b1);
    blockData = blkTwos; entryOffset = 3'd0;
    @(negedge clk);
    checkOut("R10 second", 8'h55, 4'd4, 1'b0, 1'b0);
    blockData = blkOnes; entryOffset = 3'd0;
    @(negedge clk);
    inValid = 1'b0;
    checkOut("R10 third", 8'hFF, 4'd8, 1'b0, 1'b0);
  endtask

  initial begin
    blkOnes  = {w(2'b01,1), w(2'b00,2), w(2'b01,3), w(2'b00,4),
                w(2'b01,5), w(2'b00,6), w(2'b01,7), w(2'b00,8)};
    blkTwos  = {w(2'b11,9), w(2'b10,1), w(2'b11,9), w(2'b10,2),
                w(2'b11,9), w(2'b10,3), w(2'b11,9), w(2'b10,4)};
    blkThree = {w(2'b11,9), w(2'b10,1), w(2'b11,9), w(2'b11,9),
                w(2'b11,2), w(2'b10,9), w(2'b10,9), w(2'b11,3)};
    blkStrad = {w(2'b11,1), w(2'b10,9), w(2'b10,9), w(2'b11,2),
                w(2'b10,9), w(2'b10,9), w(2'b11,3), w(2'b00,4)};
    blkSkip  = {w(2'b00,1), w(2'b01,2), w(2'b00,3), w(2'b01,4),
                w(2'b00,5), w(2'b10,9), w(2'b10,9), w(2'b11,6)};
    blkTail  = {w(2'b00,9), w(2'b11,7), w(2'b01,6), w(2'b01,5),
                w(2'b01,4), w(2'b01,3), w(2'b01,2), w(2'b01,1)};
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSingles();
    testPairs();
    testMixed();
    testStraddle();
    testSkipped();
    testTail();
    testHold();
    testBackToBack();
    @(negedge clk);
    chk("R7 outValid drops", 32'(outValid), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R7 watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule